// File: doc/BRIEF.md
# Lead/trail time-to-digital encoder

This block turns one measured pulse into two timestamps and a width. An event is presented as two strobes: a lead strobe and a trail strobe. On each strobe the block keeps a 150-tap fine-phase snapshot, taken from a parallel input bus, together with two free-running 7-bit coarse counts. The fine snapshot is a thermometer code spread over one coarse clock period. The block filters isolated bubbles out of it and reduces it to a phase index. The index then decides which coarse count is trusted. One counter runs half a period behind the other, so the chosen counter is always one whose bits were settled when the edge arrived.

Each timestamp combines the coarse and fine parts into one unsigned count of fine bins. The pulse width is the trail stamp minus the lead stamp, taken modulo the full counter span, so a counter wrap between the two edges still gives a correct positive width. A one-cycle strobe presents all three results. A calibration mode can replace either edge with a capture at a fixed counter value, so that only the other edge moves.

Top module: `pulse_span_tdc`

## Requirements
- R1: A synchronous active-high `rst_i` clears the capture state, `valid_o`, `err_o`, `lead_ts_o`, `trail_ts_o` and `width_o` to 0. It also abandons any half-finished pair, so a trail strobe after reset produces no result.
- R2: The coarse part of a capture is the number of rising clock edges since the last edge at which `rst_i` was high, modulo 128, counted up to the capturing edge. The count is 0 when the first edge after reset captures.
- R3: `snap_i[i]` is fine tap i. Each bit is first replaced by the majority of itself and its two neighbours, with a 1 assumed below bit 0 and a 0 assumed above bit 149. The index is the lowest position whose filtered bit is 1 while the next higher filtered bit (or the assumed 0) is 0. A clean code with bits 0..k set decodes to k.
- R4: One flipped bit at position j, with j at most k-2 or j at least k+3, leaves the decoded index at k.
- R5: `err_o` is high together with `valid_o` when either filtered snapshot has bit 0 equal to 0, or has a number of 1-to-0 steps other than exactly one. Otherwise `err_o` is low with the strobe.
- R6: Each timestamp equals coarse × 150 + index, as a 15-bit unsigned value below 19200.
- R7: For an index below 75 the coarse part comes from the half-period-late counter plus one. Otherwise it comes from the primary counter. Both choices give the R2 count, so indices 74 and 75 on the same edge differ by exactly 1 in the timestamp.
- R8: `width_o` equals (trail − lead) modulo 19200, including pairs whose coarse counter wrapped between the two edges.
- R9: When the trail strobe is taken at rising edge n, `valid_o` is high for exactly the one cycle after edge n+1, and is low in the cycle that follows.
- R10: A lead strobe is taken only when no pair is open, and a new pair can open at the edge that ends the `valid_o` cycle. A trail strobe is taken only while a pair waits for its trail. Strobes at any other time have no effect on the results.
- R11: With `cal_mode_i` = 2'b01, `lead_i` is ignored. The lead is captured at the first edge with no pair open at which the coarse count equals `cal_cycle_i`, with fine index 0.
- R12: With `cal_mode_i` = 2'b10, `trail_i` is ignored. The trail is captured at the first edge of an open pair at which the coarse count equals `cal_cycle_i`, with fine index 0. The codes 2'b00 and 2'b11 select normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Coarse clock; all state updates on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| lead_i | input | 1 | Lead edge strobe, sampled on the clock |
| trail_i | input | 1 | Trail edge strobe, sampled on the clock |
| snap_i | input | 150 | Fine-phase snapshot for the edge being strobed; bit i is tap i |
| cal_mode_i | input | 2 | 00/11 normal, 01 lead pinned, 10 trail pinned |
| cal_cycle_i | input | 7 | Coarse count at which a pinned edge is captured |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Snapshot decode error, meaningful with valid_o |
| lead_ts_o | output | 15 | Lead timestamp in fine bins |
| trail_ts_o | output | 15 | Trail timestamp in fine bins |
| width_o | output | 15 | Trail minus lead, modulo 19200 |

## Verification
A wrong counter offset or a wrong half-period choice shows at the first strobe as a timestamp off by exactly 150 on one side of index 75 only, so the bench steps through the indices around that boundary on both edges. A pair state that sticks or skips a step shows as a missing, doubled or early `valid_o`, which the bench sees within two cycles of the trail strobe. A decode fault shows as a fine part off by a few bins or as a wrong `err_o`, which the bench exposes with bubbles, broken codes and wrapping pairs.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    // pair progress
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_CALC = 2'd2
    } phase_e;

    // calibration pinning selector
    typedef enum logic [1:0] {
        CAL_OFF       = 2'd0,
        CAL_PIN_LEAD  = 2'd1,
        CAL_PIN_TRAIL = 2'd2,
        CAL_SPARE     = 2'd3
    } cal_e;

    localparam int EDGE_LEAD  = 0;
    localparam int EDGE_TRAIL = 1;
    localparam int N_EDGE     = 2;

endpackage

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr #(
    parameter int CW = 7
) (
    input  logic          clk_i,
    input  logic          rst_i,
    output logic [CW-1:0] prim_o,
    output logic [CW-1:0] half_o
);

    typedef struct packed {
        logic [CW-1:0] prim;
        logic [CW-1:0] half;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d.prim = ctr_q.prim + CW'(1);
        // the late counter trails the primary one by one step
        ctr_d.half = ctr_q.prim;
        if (rst_i) begin
            ctr_d.prim = '0;
            ctr_d.half = '1;
        end
    end

    always_ff @(posedge clk_i) begin
        ctr_q <= ctr_d;
    end

    assign prim_o = ctr_q.prim;
    assign half_o = ctr_q.half;

    // R7
    ctr_offset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        CW'(ctr_q.half + CW'(1)) == ctr_q.prim);

endmodule

// File: rtl/tdc_therm_dec.sv
module tdc_therm_dec #(
    parameter int NTAP = 150,
    parameter int FW   = 8
) (
    input  logic [NTAP-1:0] snap_i,
    output logic [FW-1:0]   idx_o,
    output logic            bad_o
);

    logic [NTAP+1:0] ext;
    logic [NTAP-1:0] filt;
    logic [NTAP:0]   fext;
    logic [NTAP-1:0] fall;

    // virtual 1 below tap 0, virtual 0 above the top tap
    assign ext  = {1'b0, snap_i, 1'b1};
    assign fext = {1'b0, filt};

    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        assign filt[i] = (ext[i] & ext[i+1]) | (ext[i] & ext[i+2]) | (ext[i+1] & ext[i+2]);
        assign fall[i] = fext[i] & ~fext[i+1];
    end

    always_comb begin
        idx_o = '0;
        for (int i = NTAP - 1; i >= 0; i--) begin
            if (fall[i]) begin
                idx_o = FW'(i);
            end
        end
    end

    assign bad_o = ~filt[0] | ($countones(fall) != 1);

endmodule

// File: rtl/tdc_stamp.sv
module tdc_stamp #(
    parameter int NTAP = 150,
    parameter int CW   = 7,
    parameter int FW   = 8,
    parameter int TSW  = 15
) (
    input  logic [FW-1:0]  fine_i,
    input  logic [CW-1:0]  prim_i,
    input  logic [CW-1:0]  half_i,
    output logic [TSW-1:0] ts_o
);

    localparam int HALF = NTAP / 2;

    logic [CW-1:0] coarse;

    always_comb begin
        // early half of the period: the primary counter may be settling
        if (int'(fine_i) < HALF) begin
            coarse = half_i + CW'(1);
        end else begin
            coarse = prim_i;
        end
        ts_o = TSW'(coarse) * TSW'(NTAP) + TSW'(fine_i);
    end

endmodule

// File: rtl/pulse_span_tdc.sv
module pulse_span_tdc
    import tdc_pkg::*;
#(
    parameter int NTAP = 150,
    parameter int CW   = 7
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            lead_i,
    input  logic            trail_i,
    input  logic [NTAP-1:0] snap_i,
    input  logic [1:0]      cal_mode_i,
    input  logic [CW-1:0]   cal_cycle_i,
    output logic            valid_o,
    output logic            err_o,
    output logic [$clog2(NTAP*(1<<CW))-1:0] lead_ts_o,
    output logic [$clog2(NTAP*(1<<CW))-1:0] trail_ts_o,
    output logic [$clog2(NTAP*(1<<CW))-1:0] width_o
);

    localparam int FW   = $clog2(NTAP);
    localparam int SPAN = NTAP * (1 << CW);
    localparam int TSW  = $clog2(SPAN);
    localparam logic [TSW-1:0] SPAN_T = TSW'(SPAN);
    localparam logic [TSW:0]   SPAN_X = (TSW+1)'(SPAN);
    localparam logic [NTAP-1:0] PIN_SNAP = NTAP'(1);

    typedef struct packed {
        phase_e                     ph;
        logic [N_EDGE-1:0][NTAP-1:0] snap;
        logic [N_EDGE-1:0][CW-1:0]   prim;
        logic [N_EDGE-1:0][CW-1:0]   half;
        logic                       vld;
        logic                       err;
        logic [TSW-1:0]             lts;
        logic [TSW-1:0]             tts;
        logic [TSW-1:0]             wid;
    } st_t;

    st_t st_d, st_q;

    logic [CW-1:0]                prim_w, half_w;
    logic [N_EDGE-1:0][FW-1:0]    idx_w;
    logic [N_EDGE-1:0]            bad_w;
    logic [N_EDGE-1:0][TSW-1:0]   ts_w;
    logic                         pin_lead, pin_trail, hit;
    logic                         lead_go, trail_go;
    logic [TSW-1:0]               diff;

    tdc_coarse_ctr #(.CW(CW)) u_ctr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .prim_o (prim_w),
        .half_o (half_w)
    );

    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        tdc_therm_dec #(.NTAP(NTAP), .FW(FW)) u_dec (
            .snap_i (st_q.snap[g]),
            .idx_o  (idx_w[g]),
            .bad_o  (bad_w[g])
        );
        tdc_stamp #(.NTAP(NTAP), .CW(CW), .FW(FW), .TSW(TSW)) u_stamp (
            .fine_i (idx_w[g]),
            .prim_i (st_q.prim[g]),
            .half_i (st_q.half[g]),
            .ts_o   (ts_w[g])
        );
    end

    assign pin_lead  = (cal_mode_i == CAL_PIN_LEAD);
    assign pin_trail = (cal_mode_i == CAL_PIN_TRAIL);
    assign hit       = (prim_w == cal_cycle_i);
    assign lead_go   = pin_lead  ? hit : lead_i;
    assign trail_go  = pin_trail ? hit : trail_i;

    always_comb begin
        diff = ts_w[EDGE_TRAIL] - ts_w[EDGE_LEAD];
        if (ts_w[EDGE_TRAIL] < ts_w[EDGE_LEAD]) begin
            diff = diff + SPAN_T;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (lead_go) begin
                    st_d.snap[EDGE_LEAD] = pin_lead ? PIN_SNAP : snap_i;
                    st_d.prim[EDGE_LEAD] = prim_w;
                    st_d.half[EDGE_LEAD] = half_w;
                    st_d.ph              = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (trail_go) begin
                    st_d.snap[EDGE_TRAIL] = pin_trail ? PIN_SNAP : snap_i;
                    st_d.prim[EDGE_TRAIL] = prim_w;
                    st_d.half[EDGE_TRAIL] = half_w;
                    st_d.ph               = PH_CALC;
                end
            end
            PH_CALC: begin
                st_d.vld = 1'b1;
                st_d.err = bad_w[EDGE_LEAD] | bad_w[EDGE_TRAIL];
                st_d.lts = ts_w[EDGE_LEAD];
                st_d.tts = ts_w[EDGE_TRAIL];
                st_d.wid = diff;
                st_d.ph  = PH_IDLE;
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign valid_o    = st_q.vld;
    assign err_o      = st_q.err;
    assign lead_ts_o  = st_q.lts;
    assign trail_ts_o = st_q.tts;
    assign width_o    = st_q.wid;

    // R9
    valid_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);

    // R9
    valid_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> $past(st_q.ph) == PH_CALC);

    // R6
    ts_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (lead_ts_o < SPAN_T) && (trail_ts_o < SPAN_T));

    // R8
    width_sum_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (width_o < SPAN_T) &&
                    ((({1'b0, lead_ts_o} + {1'b0, width_o}) == {1'b0, trail_ts_o}) ||
                     (({1'b0, lead_ts_o} + {1'b0, width_o}) == ({1'b0, trail_ts_o} + SPAN_X))));

    // R10
    lead_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.ph != PH_IDLE) |=> $stable(st_q.snap[EDGE_LEAD]));

endmodule

// File: tb/sim_pulse_span_tdc.sv
`timescale 1ns/1ps
module sim_pulse_span_tdc;

    localparam int NTAP = 150;
    localparam int CW   = 7;
    localparam int SPAN = NTAP * 128;
    localparam int TSW  = 15;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            lead = 1'b0;
    logic            trail = 1'b0;
    logic [NTAP-1:0] snap = '0;
    logic [1:0]      cal_mode = 2'd0;
    logic [CW-1:0]   cal_cycle = '0;
    logic            valid, err;
    logic [TSW-1:0]  lts, tts, wid;

    int mc = 0;
    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // R2: coarse count seen by the design during the current cycle
    always @(posedge clk) mc <= rst ? 0 : (mc + 1) % 128;

    pulse_span_tdc #(.NTAP(NTAP), .CW(CW)) u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .lead_i      (lead),
        .trail_i     (trail),
        .snap_i      (snap),
        .cal_mode_i  (cal_mode),
        .cal_cycle_i (cal_cycle),
        .valid_o     (valid),
        .err_o       (err),
        .lead_ts_o   (lts),
        .trail_ts_o  (tts),
        .width_o     (wid)
    );

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    function automatic logic [NTAP-1:0] therm(int k, int bub);
        logic [NTAP-1:0] s;
        for (int i = 0; i < NTAP; i++) s[i] = (i <= k);
        if (bub >= 0) s[bub] = ~s[bub];
        return s;
    endfunction

    function automatic logic [NTAP-1:0] noise();
        logic [NTAP-1:0] s;
        for (int i = 0; i < NTAP; i++) s[i] = 1'($urandom_range(1, 0));
        return s;
    endfunction

    // R4: bubble positions that the majority filter must absorb
    function automatic int pick_bub(int k);
        int r;
        r = int'($urandom_range(2, 0));
        if (r == 0 && k >= 2) return int'($urandom_range(k - 2, 0));
        if (r == 1 && k + 3 <= NTAP - 1) return int'($urandom_range(NTAP - 1, k + 3));
        return -1;
    endfunction

    // called at the falling edge after the strobe should have risen
    task automatic check_out(int lc, int lk, int tc, int tk, bit exp_err, string req);
        int el, et, ew;
        el = lc * NTAP + lk;
        et = tc * NTAP + tk;
        ew = (et - el + SPAN) % SPAN;
        chk({req, " R9"}, "valid", int'(valid), 1);
        chk({req, " R5"}, "err", int'(err), int'(exp_err));
        if (!exp_err) begin
            chk({req, " R6"}, "lead_ts", int'(lts), el);
            chk({req, " R6"}, "trail_ts", int'(tts), et);
            chk({req, " R8"}, "width", int'(wid), ew);
        end
        @(negedge clk);
        chk("R9", "strobe end", int'(valid), 0);
    endtask

    task automatic run_pair(logic [NTAP-1:0] ls, int lk, logic [NTAP-1:0] tsn, int tk,
                            int gap, bit exp_err, string req);
        int lc, tc;
        @(negedge clk);
        lead = 1'b1; snap = ls; lc = mc;
        @(negedge clk);
        lead = 1'b0; snap = noise();
        for (int j = 0; j < gap; j++) begin
            @(negedge clk);
            // R10: extra lead strobe inside an open pair must be ignored
            lead = (j == 0 && gap >= 2);
            snap = noise();
        end
        trail = 1'b1; snap = tsn; tc = mc;
        @(negedge clk);
        trail = 1'b0; snap = noise();
        @(negedge clk);
        check_out(lc, lk, tc, tk, exp_err, req);
    endtask

    task automatic run_pin_lead(int c, int gap, int tk);
        int tc;
        @(negedge clk);
        cal_mode = 2'd1; cal_cycle = CW'(c); lead = 1'b1; snap = noise();
        while (mc != c) begin
            @(negedge clk);
            snap = noise();
        end
        @(negedge clk);
        lead = 1'b0;
        for (int j = 0; j < gap; j++) @(negedge clk);
        trail = 1'b1; snap = therm(tk, -1); tc = mc;
        @(negedge clk);
        trail = 1'b0; snap = noise();
        @(negedge clk);
        cal_mode = 2'd0;
        check_out(c, 0, tc, tk, 1'b0, "R11");
    endtask

    task automatic run_pin_trail(int c, int lk);
        int lc;
        @(negedge clk);
        cal_mode = 2'd2; cal_cycle = CW'(c); lead = 1'b1; trail = 1'b1;
        snap = therm(lk, -1); lc = mc;
        @(negedge clk);
        lead = 1'b0; snap = noise();
        while (mc != c) begin
            @(negedge clk);
            snap = noise();
        end
        @(negedge clk);
        @(negedge clk);
        cal_mode = 2'd0; trail = 1'b0;
        check_out(lc, lk, c, 0, 1'b0, "R12");
    endtask

    initial begin
        logic [NTAP-1:0] two_runs;
        void'($urandom(32'h5EED));

        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1", "valid", int'(valid), 0);
        chk("R1", "err", int'(err), 0);
        chk("R1", "lead_ts", int'(lts), 0);
        chk("R1", "trail_ts", int'(tts), 0);
        chk("R1", "width", int'(wid), 0);
        rst = 1'b0;

        // R2 R3 R6: first pair right after reset, index extremes
        run_pair(therm(0, -1), 0, therm(149, -1), 149, 5, 1'b0, "R2 R3");
        // R7: both sides of the counter choice
        run_pair(therm(74, -1), 74, therm(75, -1), 75, 0, 1'b0, "R7");
        run_pair(therm(75, -1), 75, therm(74, -1), 74, 3, 1'b0, "R7");
        run_pair(therm(1, -1), 1, therm(148, -1), 148, 1, 1'b0, "R7");

        // R8: pair spanning a counter wrap
        while (mc != 120) @(negedge clk);
        run_pair(therm(100, -1), 100, therm(10, -1), 10, 20, 1'b0, "R8");

        // R4: bubbles on both sides of the step
        run_pair(therm(50, 10), 50, therm(100, 140), 100, 7, 1'b0, "R4");
        run_pair(therm(2, 0), 2, therm(146, 149), 146, 2, 1'b0, "R4");

        // R5: broken codes
        run_pair('0, 0, therm(30, -1), 30, 4, 1'b1, "R5");
        two_runs = therm(20, -1) | (therm(80, -1) & ~therm(59, -1));
        run_pair(therm(40, -1), 40, two_runs, 0, 4, 1'b1, "R5");
        run_pair(therm(40, -1), 40, therm(41, -1), 41, 4, 1'b0, "R5");

        // R10: trail with no open pair has no effect
        @(negedge clk);
        trail = 1'b1; snap = therm(5, -1);
        @(negedge clk);
        trail = 1'b0;
        @(negedge clk);
        chk("R10", "valid after lone trail", int'(valid), 0);
        @(negedge clk);
        chk("R10", "valid after lone trail", int'(valid), 0);
        run_pair(therm(12, -1), 12, therm(13, -1), 13, 6, 1'b0, "R10");

        // R11 R12: calibration pinning
        run_pin_lead(40, 9, 88);
        run_pin_lead(5, 0, 3);
        run_pin_trail(10, 120);
        run_pin_trail(77, 60);

        // random pairs
        for (int n = 0; n < 40; n++) begin
            int lk, tk;
            lk = int'($urandom_range(NTAP - 1, 0));
            tk = int'($urandom_range(NTAP - 1, 0));
            run_pair(therm(lk, pick_bub(lk)), lk, therm(tk, pick_bub(tk)), tk,
                     int'($urandom_range(260, 0)), 1'b0, "R3 R8 random");
        end

        // R1: reset in the middle of a pair
        @(negedge clk);
        lead = 1'b1; snap = therm(10, -1);
        @(negedge clk);
        lead = 1'b0; rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; trail = 1'b1; snap = therm(20, -1);
        @(negedge clk);
        trail = 1'b0;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk("R1", "no result after reset", int'(valid), 0);
        end
        chk("R1", "lead_ts cleared", int'(lts), 0);
        run_pair(therm(90, -1), 90, therm(91, -1), 91, 2, 1'b0, "R1 R2");

        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

endmodule